// File: doc/BRIEF.md
# Register-Indirect Jump Decoder with Hazard Barrier

This block sits beside the decode stage of a 32-bit RISC pipeline and handles the jump-through-register instruction. When a jump-register word arrives, the block checks its encoding, takes the source register value, and waits for the next instruction. That next instruction is the delay slot, and it executes before control moves. Once the slot instruction has been accepted, the block either issues the redirect to the target address or, when the barrier bit is set, first flushes the front end and holds fetch until the pipeline reports that it has drained.

An encoding-mode input selects between the legacy encoding and the newer encoding. A configuration input states whether a compressed instruction set is present. When one is present, bit 0 of the target is split off as an instruction-set mode bit. The alignment-fault flag travels with the redirect, so that it is raised when the target is fetched and not when the jump executes. In the newer mode, a control-transfer instruction found in the delay slot cancels the jump and raises a reserved-instruction exception.

Top module: `jrhb_unit`

## Requirements
- R1: After a synchronous active-high reset, `redirect_valid`, `rsvd_exc`, `flush_req` and `fetch_stall` are low and no jump is pending, so the next instruction word produces no output.
- R2: In legacy mode (`newer_mode`=0), the block accepts a word as a jump-register when all of these hold: bits 31:26 = 000000, bits 5:0 = 001000, bits 20:11 = 0 and bits 9:6 = 0. The next accepted word is the delay slot. `redirect_valid` pulses for one cycle in the cycle after that slot word is accepted.
- R3: In newer mode, the block accepts a word as a jump-register when all of these hold: bits 31:26 = 000000, bits 5:0 = 001001, bits 15:11 (rd) = 0, bits 20:16 = 0 and bits 9:6 = 0. It then behaves as in R2. A word with this function code and rd nonzero is not decoded and has no effect.
- R4: `rsvd_exc` pulses for one cycle in the cycle after the word and no jump is taken, in any of these cases:
  - a jump-register word has a nonzero reserved field (see R2 and R3);
  - in newer mode, the legacy function code 001000 appears under opcode 000000.
- R5: The target is the `rs_val` present on the cycle the jump word is accepted. Later changes on `rs_val` do not alter it.
- R6: With `cmp_isa`=0 captured at the jump, `next_pc` equals the target and `isa_mode`=0. `addr_err`=1 exactly when target bits 1:0 are not 00.
- R7: With `cmp_isa`=1 captured at the jump:
  - `next_pc` is the target with bit 0 cleared;
  - `isa_mode` equals target bit 0;
  - `addr_err`=1 exactly when target bits 1:0 = 10.
- R8: With bit 10 of the jump word set, acceptance of the slot word raises `flush_req` for exactly one cycle and raises `fetch_stall` in that same cycle. `fetch_stall` stays high while `drained` is low. In the cycle after `drained` is sampled high, `fetch_stall` falls and `redirect_valid` pulses.
- R9: In newer mode, a control-transfer word in the delay slot raises `rsvd_exc` and cancels the jump. Control-transfer words are:
  - opcode 000001, 000010, 000011 or 0001xx;
  - opcode 000000 with function 001000 or 001001;
  - opcode 010000 with bit 25 set and function 011000, 011111 or 100000;
  - the word 32'h0000_0140.
- R10: In legacy mode, a control-transfer word in the delay slot raises no exception and the jump completes normally.
- R11: Words that are not jump-register encodings while no jump is pending, and any word accepted while waiting for drain, have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the source register for the presented word |
| newer_mode | input | 1 | 1 selects the newer encoding rules |
| cmp_isa | input | 1 | 1 when a compressed instruction set is configured |
| drained | input | 1 | Pipeline reports all older work has drained |
| redirect_valid | output | 1 | One-cycle pulse: fetch from `next_pc` |
| next_pc | output | 32 | Jump target for the fetch |
| isa_mode | output | 1 | Instruction-set mode for the target |
| addr_err | output | 1 | The target fetch must take an address error |
| flush_req | output | 1 | One-cycle flush request to fetch and decode |
| fetch_stall | output | 1 | Hold target fetch until drain completes |
| rsvd_exc | output | 1 | One-cycle reserved-instruction exception |

## Verification
A wrong internal state shows up as an output at the wrong time:
- A lost pending-jump state drops the redirect after the slot word, which is visible one cycle after that word.
- A stuck pending state turns an ordinary later word into a spurious redirect.
- A barrier that skips the drain wait shows `redirect_valid` without the preceding `flush_req` and `fetch_stall` window.
- A target register that is not held until redirect shows a `next_pc` that tracks `rs_val` instead of the value captured at the jump.

Every one of these faults appears on the ports within two cycles of the delay-slot word, or within one cycle of `drained`.

// File: rtl/jrhb_pkg.sv
package jrhb_pkg;

    localparam logic [5:0] OP_SPECIAL = 6'b000000;
    localparam logic [5:0] OP_REGIMM  = 6'b000001;
    localparam logic [5:0] OP_J       = 6'b000010;
    localparam logic [5:0] OP_JAL     = 6'b000011;
    localparam logic [5:0] OP_COP0    = 6'b010000;

    localparam logic [5:0] FN_JR_OLD  = 6'b001000;
    localparam logic [5:0] FN_JR_NEW  = 6'b001001;
    localparam logic [5:0] FN_XRET    = 6'b011000;
    localparam logic [5:0] FN_DXRET   = 6'b011111;
    localparam logic [5:0] FN_IDLE    = 6'b100000;

    localparam logic [31:0] PAUSE_WORD = 32'h0000_0140;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SLOT,
        ST_DRAIN
    } jr_state_e;

    typedef struct packed {
        logic is_jump;
        logic bad_enc;
        logic barrier;
    } jr_dec_t;

    // Control-transfer classification of a delay-slot word
    function automatic logic is_cti(input logic [31:0] w);
        logic [5:0] op;
        logic [5:0] fn;
        op = w[31:26];
        fn = w[5:0];
        is_cti = 1'b0;
        if (op == OP_REGIMM || op == OP_J || op == OP_JAL || op[5:2] == 4'b0001)
            is_cti = 1'b1;
        if (op == OP_SPECIAL && (fn == FN_JR_OLD || fn == FN_JR_NEW))
            is_cti = 1'b1;
        if (op == OP_COP0 && w[25] && (fn == FN_XRET || fn == FN_DXRET || fn == FN_IDLE))
            is_cti = 1'b1;
        if (w == PAUSE_WORD)
            is_cti = 1'b1;
    endfunction

endpackage

// File: rtl/jrhb_decode.sv
module jrhb_decode
    import jrhb_pkg::*;
(
    input  logic       newer_mode,
    input  logic [5:0] op,
    input  logic [4:0] rt,
    input  logic [4:0] rd,
    input  logic [4:0] hint,
    input  logic [5:0] fn,
    output jr_dec_t    dec
);
    logic resv_old;
    logic resv_new;

    assign resv_old = (rt != 5'd0) || (rd != 5'd0) || (hint[3:0] != 4'd0);
    assign resv_new = (rt != 5'd0) || (hint[3:0] != 4'd0);

    always_comb begin
        dec = '0;
        dec.barrier = hint[4];
        if (op == OP_SPECIAL) begin
            if (!newer_mode) begin
                if (fn == FN_JR_OLD) begin
                    dec.is_jump = !resv_old;
                    dec.bad_enc = resv_old;
                end
            end else begin
                if (fn == FN_JR_OLD) begin
                    dec.bad_enc = 1'b1;
                end else if (fn == FN_JR_NEW && rd == 5'd0) begin
                    dec.is_jump = !resv_new;
                    dec.bad_enc = resv_new;
                end
            end
        end
    end
endmodule

// File: rtl/jrhb_slot_check.sv
module jrhb_slot_check
    import jrhb_pkg::*;
(
    input  logic [31:0] word,
    output logic        cti
);
    assign cti = is_cti(word);
endmodule

// File: rtl/jrhb_target.sv
module jrhb_target #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] value,
    input  logic            cmp,
    output logic [XLEN-1:0] pc,
    output logic            isa,
    output logic            aerr
);
    generate
        if (XLEN > 2) begin : g_split
            always_comb begin
                if (cmp) begin
                    pc   = {value[XLEN-1:1], 1'b0};
                    isa  = value[0];
                    aerr = (value[1:0] == 2'b10);
                end else begin
                    pc   = value;
                    isa  = 1'b0;
                    aerr = (value[1:0] != 2'b00);
                end
            end
        end else begin : g_tiny
            assign pc   = value;
            assign isa  = 1'b0;
            assign aerr = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/jrhb_unit.sv
module jrhb_unit
    import jrhb_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs_val,
    input  logic            newer_mode,
    input  logic            cmp_isa,
    input  logic            drained,
    output logic            redirect_valid,
    output logic [XLEN-1:0] next_pc,
    output logic            isa_mode,
    output logic            addr_err,
    output logic            flush_req,
    output logic            fetch_stall,
    output logic            rsvd_exc
);
    jr_state_e       state_q;
    logic [XLEN-1:0] tgt_q;
    logic            cmp_q;
    logic            hb_q;

    jr_dec_t         dec;
    logic            slot_cti;
    logic [XLEN-1:0] tgt_pc;
    logic            tgt_isa;
    logic            tgt_aerr;

    jrhb_decode u_dec (
        .newer_mode (newer_mode),
        .op         (instr[31:26]),
        .rt         (instr[20:16]),
        .rd         (instr[15:11]),
        .hint       (instr[10:6]),
        .fn         (instr[5:0]),
        .dec        (dec)
    );

    jrhb_slot_check u_slot (
        .word (instr),
        .cti  (slot_cti)
    );

    jrhb_target #(.XLEN(XLEN)) u_tgt (
        .value (tgt_q),
        .cmp   (cmp_q),
        .pc    (tgt_pc),
        .isa   (tgt_isa),
        .aerr  (tgt_aerr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_IDLE;
            tgt_q          <= '0;
            cmp_q          <= 1'b0;
            hb_q           <= 1'b0;
            redirect_valid <= 1'b0;
            next_pc        <= '0;
            isa_mode       <= 1'b0;
            addr_err       <= 1'b0;
            flush_req      <= 1'b0;
            fetch_stall    <= 1'b0;
            rsvd_exc       <= 1'b0;
        end else begin
            redirect_valid <= 1'b0;
            flush_req      <= 1'b0;
            rsvd_exc       <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (instr_valid) begin
                        if (dec.bad_enc) begin
                            rsvd_exc <= 1'b1;
                        end else if (dec.is_jump) begin
                            tgt_q   <= rs_val;
                            cmp_q   <= cmp_isa;
                            hb_q    <= dec.barrier;
                            state_q <= ST_SLOT;
                        end
                    end
                end
                ST_SLOT: begin
                    if (instr_valid) begin
                        if (newer_mode && slot_cti) begin
                            rsvd_exc <= 1'b1;
                            state_q  <= ST_IDLE;
                        end else if (hb_q) begin
                            flush_req   <= 1'b1;
                            fetch_stall <= 1'b1;
                            state_q     <= ST_DRAIN;
                        end else begin
                            redirect_valid <= 1'b1;
                            next_pc        <= tgt_pc;
                            isa_mode       <= tgt_isa;
                            addr_err       <= tgt_aerr;
                            state_q        <= ST_IDLE;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (drained) begin
                        fetch_stall    <= 1'b0;
                        redirect_valid <= 1'b1;
                        next_pc        <= tgt_pc;
                        isa_mode       <= tgt_isa;
                        addr_err       <= tgt_aerr;
                        state_q        <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/jrhb_unit_chk.sv
module jrhb_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            drained,
    input logic            redirect_valid,
    input logic [XLEN-1:0] next_pc,
    input logic            isa_mode,
    input logic            addr_err,
    input logic            flush_req,
    input logic            fetch_stall,
    input logic            rsvd_exc
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!redirect_valid && !rsvd_exc && !flush_req && !fetch_stall));

    // R8
    flush_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> !flush_req);

    // R8
    stall_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_stall) |-> flush_req);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_stall && !drained) |=> fetch_stall);

    // R8
    stall_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fetch_stall) |-> redirect_valid);

    // R4
    exc_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        rsvd_exc |-> !redirect_valid);

    // R7
    isa_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (redirect_valid && isa_mode) |-> !next_pc[0]);

    // R6
    aerr_align_chk: assert property (@(posedge clk) disable iff (rst)
        (redirect_valid && addr_err) |-> (next_pc[1:0] != 2'b00));
endmodule

bind jrhb_unit jrhb_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .drained        (drained),
    .redirect_valid (redirect_valid),
    .next_pc        (next_pc),
    .isa_mode       (isa_mode),
    .addr_err       (addr_err),
    .flush_req      (flush_req),
    .fetch_stall    (fetch_stall),
    .rsvd_exc       (rsvd_exc)
);

// File: tb/jrhb_unit_test.sv
module jrhb_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic        newer_mode = 1'b0;
    logic        cmp_isa = 1'b0;
    logic        drained = 1'b0;
    logic        redirect_valid;
    logic [31:0] next_pc;
    logic        isa_mode;
    logic        addr_err;
    logic        flush_req;
    logic        fetch_stall;
    logic        rsvd_exc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          exc;
        logic [31:0] pc;
        bit          isa;
        bit          aerr;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    jrhb_unit uut (
        .clk            (clk),
        .rst            (rst),
        .instr_valid    (instr_valid),
        .instr          (instr),
        .rs_val         (rs_val),
        .newer_mode     (newer_mode),
        .cmp_isa        (cmp_isa),
        .drained        (drained),
        .redirect_valid (redirect_valid),
        .next_pc        (next_pc),
        .isa_mode       (isa_mode),
        .addr_err       (addr_err),
        .flush_req      (flush_req),
        .fetch_stall    (fetch_stall),
        .rsvd_exc       (rsvd_exc)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops an expected item whenever the design reports a result
    always @(negedge clk) begin
        if (!rst && (redirect_valid || rsvd_exc)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11", "unexpected output", {30'd0, rsvd_exc, redirect_valid}, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.exc) begin
                    chk(rsvd_exc && !redirect_valid, e.tag, "exception",
                        {30'd0, rsvd_exc, redirect_valid}, 32'd2);
                end else begin
                    chk(redirect_valid && !rsvd_exc, e.tag, "redirect",
                        {30'd0, rsvd_exc, redirect_valid}, 32'd1);
                    chk(next_pc == e.pc, e.tag, "next_pc", next_pc, e.pc);
                    chk(isa_mode == e.isa, e.tag, "isa_mode", {31'd0, isa_mode}, {31'd0, e.isa});
                    chk(addr_err == e.aerr, e.tag, "addr_err", {31'd0, addr_err}, {31'd0, e.aerr});
                end
            end
        end
    end

    function automatic logic [31:0] jr_old(input bit hb);
        return {6'd0, 5'd31, 10'd0, hb, 4'd0, 6'b001000};
    endfunction

    function automatic logic [31:0] jr_new(input bit hb);
        return {6'd0, 5'd31, 5'd0, 5'd0, hb, 4'd0, 6'b001001};
    endfunction

    task automatic send(input logic [31:0] w, input logic [31:0] v);
        @(negedge clk);
        instr_valid = 1'b1;
        instr = w;
        rs_val = v;
        @(negedge clk);
        instr_valid = 1'b0;
        rs_val = 32'hDEAD_BEEF;
    endtask

    task automatic push_redirect(input logic [31:0] pc, input bit isa, input bit aerr, input string tag);
        exp_t e;
        e.exc = 0; e.pc = pc; e.isa = isa; e.aerr = aerr; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic push_exc(input string tag);
        exp_t e;
        e.exc = 1; e.pc = '0; e.isa = 0; e.aerr = 0; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!redirect_valid && !rsvd_exc, tag, "no output expected",
                {30'd0, rsvd_exc, redirect_valid}, 32'd0);
        end
    endtask

    task automatic plain_jump(input logic [31:0] jw, input logic [31:0] v, input logic [31:0] slot,
                              input logic [31:0] pc, input bit isa, input bit aerr, input string tag);
        send(jw, v);
        push_redirect(pc, isa, aerr, tag);
        send(slot, 32'h1111_2222);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!redirect_valid && !rsvd_exc && !flush_req && !fetch_stall, "R1", "reset outputs",
            {28'd0, redirect_valid, rsvd_exc, flush_req, fetch_stall}, 32'd0);
        rst = 1'b0;
        // R1: no jump pending after reset, a word produces nothing
        send(32'h0000_0000, 32'h0);
        quiet(2, "R1");

        // R11: ignored words in idle (nop, newer-form with rd nonzero)
        newer_mode = 1'b1;
        send({6'd0, 5'd31, 5'd0, 5'd31, 1'b0, 4'd0, 6'b001001}, 32'h4000);
        send(32'h0000_0000, 32'h0);
        quiet(2, "R11");
        newer_mode = 1'b0;

        // R2 and R5: legacy jump, rs_val changes during slot
        plain_jump(jr_old(0), 32'h0040_1000, 32'h0, 32'h0040_1000, 0, 0, "R2");
        plain_jump(jr_old(0), 32'h0000_8000, 32'h0, 32'h0000_8000, 0, 0, "R5");

        // R6: no compressed ISA alignment
        plain_jump(jr_old(0), 32'h0000_1002, 32'h0, 32'h0000_1002, 0, 1, "R6");
        plain_jump(jr_old(0), 32'h0000_1001, 32'h0, 32'h0000_1001, 0, 1, "R6");

        // R7: compressed ISA present
        cmp_isa = 1'b1;
        plain_jump(jr_old(0), 32'h0000_1235, 32'h0, 32'h0000_1234, 1, 0, "R7");
        plain_jump(jr_old(0), 32'h0000_1236, 32'h0, 32'h0000_1236, 0, 1, "R7");
        plain_jump(jr_old(0), 32'h0000_1237, 32'h0, 32'h0000_1236, 1, 0, "R7");
        cmp_isa = 1'b0;

        // R3: newer encoding
        newer_mode = 1'b1;
        plain_jump(jr_new(0), 32'h0080_0040, 32'h0, 32'h0080_0040, 0, 0, "R3");

        // R4: reserved encodings
        push_exc("R4");
        send({6'd0, 5'd31, 5'd3, 5'd0, 1'b0, 4'd0, 6'b001001}, 32'h100);
        push_exc("R4");
        send(jr_old(0), 32'h100);
        push_exc("R4");
        send({6'd0, 5'd31, 5'd0, 5'd0, 1'b0, 4'b0010, 6'b001001}, 32'h100);
        newer_mode = 1'b0;
        push_exc("R4");
        send({6'd0, 5'd31, 5'd0, 5'd1, 1'b0, 4'd0, 6'b001000}, 32'h100);
        quiet(2, "R4");

        // R9: control transfer in slot, newer mode
        newer_mode = 1'b1;
        send(jr_new(0), 32'h200);
        push_exc("R9");
        send(32'h1000_0004, 32'h0);
        send(jr_new(0), 32'h200);
        push_exc("R9");
        send(32'h4200_0018, 32'h0);
        send(jr_new(0), 32'h200);
        push_exc("R9");
        send(32'h0000_0140, 32'h0);
        send(jr_new(0), 32'h200);
        push_exc("R9");
        send(32'h0800_0010, 32'h0);
        quiet(2, "R9");
        newer_mode = 1'b0;

        // R10: legacy mode ignores a branch in slot
        plain_jump(jr_old(0), 32'h0000_3000, 32'h1000_0004, 32'h0000_3000, 0, 0, "R10");

        // R8: barrier with a drain wait, plus R11 ignored word while draining
        drained = 1'b0;
        send(jr_old(1), 32'h0000_5000);
        send(32'h0, 32'h0);
        chk(flush_req && fetch_stall && !redirect_valid, "R8", "flush and stall start",
            {29'd0, flush_req, fetch_stall, redirect_valid}, 32'd6);
        send(jr_old(0), 32'h0000_9000);
        chk(!flush_req && fetch_stall, "R8", "flush one cycle, stall held",
            {30'd0, flush_req, fetch_stall}, 32'd1);
        quiet(2, "R11");
        chk(fetch_stall, "R8", "stall held while not drained", {31'd0, fetch_stall}, 32'd1);
        push_redirect(32'h0000_5000, 0, 0, "R8");
        drained = 1'b1;
        @(negedge clk);
        drained = 1'b0;
        chk(!fetch_stall, "R8", "stall released", {31'd0, fetch_stall}, 32'd0);
        quiet(2, "R11");

        // R8: drained already high
        drained = 1'b1;
        send(jr_old(1), 32'h0000_6000);
        send(32'h0, 32'h0);
        chk(flush_req && fetch_stall, "R8", "flush with drained high",
            {30'd0, flush_req, fetch_stall}, 32'd3);
        push_redirect(32'h0000_6000, 0, 0, "R8");
        @(negedge clk);
        chk(!fetch_stall, "R8", "immediate release", {31'd0, fetch_stall}, 32'd0);
        drained = 1'b0;

        quiet(3, "R11");
        chk(sb.size() == 0, "R2", "all expected results seen", sb.size(), 32'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule